// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits beside a two-port shared memory. It watches each port's request pins and keeps one interrupt flag per port, presented active-low. The top word of the address space belongs to the right port and the word just below it belongs to the left port. When one port writes into the mailbox word of the other port, the owner's flag is raised. The owner lowers its own flag again by reading its mailbox with both select and output enable active.

A port whose busy input from the arbiter is active can neither raise the flag of the opposite port nor lower its own. The message data lives in the ordinary memory array and does not pass through this block. Arbitration between the ports also happens elsewhere.

All pins are plain, level-sampled control signals. A request counts in the clock cycle in which it is present. The flags are registered, so an output changes one clock edge after the request that caused it.

Top module: `mbx_irq_top`

## Requirements
- R1: While reset (rst_n low) is active, and on leaving it, both l_irq_n and r_irq_n are 1 (no interrupt pending).
- R2: A cycle with l_sel=1, l_wr=1, l_busy=0 and l_addr equal to all ones (2^AW-1) drives r_irq_n to 0 after the next rising clock edge.
- R3: A cycle with r_sel=1, r_wr=1, r_busy=0 and r_addr equal to 2^AW-2 drives l_irq_n to 0 after the next rising clock edge.
- R4: A cycle with l_sel=1, l_wr=0, l_oe=1, l_busy=0 and l_addr=2^AW-2 returns l_irq_n to 1 after the next edge, unless R9 applies.
- R5: A cycle with r_sel=1, r_wr=0, r_oe=1, r_busy=0 and r_addr=2^AW-1 returns r_irq_n to 1 after the next edge, unless R9 applies. A read with r_oe=0 does not clear the flag.
- R6: A port that reads the mailbox of the other port leaves both flags unchanged.
- R7: A write to the mailbox of the opposite port while the writer's busy input is 1 does not raise that port's flag.
- R8: A read of a port's own mailbox while that port's busy input is 1 does not clear its flag.
- R9: When a raise and a clear of the same flag fall in the same cycle, the flag ends up raised (output 0).
- R10: Writes by a port into its own mailbox, writes to any other address, and requests with the select pin low change neither flag.
- R11: Without a qualifying raise or clear, each flag holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left port access select, active high |
| l_wr | input | 1 | Left port direction: 1 write, 0 read |
| l_oe | input | 1 | Left port output enable, active high |
| l_busy | input | 1 | Busy from the arbiter to the left port, active high |
| l_addr | input | AW | Left port word address |
| r_sel | input | 1 | Right port access select, active high |
| r_wr | input | 1 | Right port direction: 1 write, 0 read |
| r_oe | input | 1 | Right port output enable, active high |
| r_busy | input | 1 | Busy from the arbiter to the right port, active high |
| r_addr | input | AW | Right port word address |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The bench builds the block with AW=4. This places the two mailbox words at 0xF and 0xE, next to ordinary addresses such as 0x3, so that near misses and exact hits can be driven with short vectors. The bench works through these cases:
- collisions in the same cycle, where one port posts while the other port takes;
- busy on the writer and busy on the reader;
- reads without output enable;
- a port reading the other port's mailbox.

Each case is compared against a flag model that the bench keeps from the requirements.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Side index used for the per-port arrays
  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;
  localparam int NUM_SIDES = 2;

  // Decoded mailbox events of one port for one cycle
  typedef struct packed {
    logic post; // write into the peer's mailbox
    logic take; // qualified read of own mailbox
  } mbx_evt_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int AW = 15,
  parameter logic [AW-1:0] OWN_ADDR = '1,
  parameter logic [AW-1:0] PEER_ADDR = '1
) (
  input  logic          sel,
  input  logic          wr,
  input  logic          oe,
  input  logic          busy,
  input  logic [AW-1:0] addr,
  output mbx_pkg::mbx_evt_t evt
);
  logic granted;
  logic hit_own;
  logic hit_peer;

  always_comb begin
    granted  = sel && !busy;
    hit_own  = (addr == OWN_ADDR);
    hit_peer = (addr == PEER_ADDR);
    evt.post = granted && wr && hit_peer;
    evt.take = granted && !wr && oe && hit_own;
  end
endmodule

// File: rtl/mbx_flag_cell.sv
module mbx_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic raised_o
);
  // Set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     raised_o <= 1'b0;
    else if (set_i) raised_o <= 1'b1;
    else if (clr_i) raised_o <= 1'b0;
  end
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel,
  input  logic          l_wr,
  input  logic          l_oe,
  input  logic          l_busy,
  input  logic [AW-1:0] l_addr,
  input  logic          r_sel,
  input  logic          r_wr,
  input  logic          r_oe,
  input  logic          r_busy,
  input  logic [AW-1:0] r_addr,
  output logic          l_irq_n,
  output logic          r_irq_n
);
  import mbx_pkg::*;

  localparam logic [AW-1:0] TOP_WORD  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT_WORD = TOP_WORD - 1'b1;

  logic          p_sel  [NUM_SIDES];
  logic          p_wr   [NUM_SIDES];
  logic          p_oe   [NUM_SIDES];
  logic          p_busy [NUM_SIDES];
  logic [AW-1:0] p_addr [NUM_SIDES];
  mbx_evt_t      p_evt  [NUM_SIDES];
  logic          raised [NUM_SIDES];

  always_comb begin
    p_sel[SIDE_L]  = l_sel;   p_sel[SIDE_R]  = r_sel;
    p_wr[SIDE_L]   = l_wr;    p_wr[SIDE_R]   = r_wr;
    p_oe[SIDE_L]   = l_oe;    p_oe[SIDE_R]   = r_oe;
    p_busy[SIDE_L] = l_busy;  p_busy[SIDE_R] = r_busy;
    p_addr[SIDE_L] = l_addr;  p_addr[SIDE_R] = r_addr;
  end

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    // Left owns the word below the top, right owns the top word
    localparam logic [AW-1:0] OWN  = (g == SIDE_L) ? NEXT_WORD : TOP_WORD;
    localparam logic [AW-1:0] PEER = (g == SIDE_L) ? TOP_WORD : NEXT_WORD;

    mbx_port_decode #(.AW(AW), .OWN_ADDR(OWN), .PEER_ADDR(PEER)) u_dec (
      .sel  (p_sel[g]),
      .wr   (p_wr[g]),
      .oe   (p_oe[g]),
      .busy (p_busy[g]),
      .addr (p_addr[g]),
      .evt  (p_evt[g])
    );

    mbx_flag_cell u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (p_evt[NUM_SIDES-1-g].post),
      .clr_i    (p_evt[g].take),
      .raised_o (raised[g])
    );
  end

  assign l_irq_n = !raised[SIDE_L];
  assign r_irq_n = !raised[SIDE_R];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_sel,
  input logic          l_wr,
  input logic          l_oe,
  input logic          l_busy,
  input logic [AW-1:0] l_addr,
  input logic          r_sel,
  input logic          r_wr,
  input logic          r_oe,
  input logic          r_busy,
  input logic [AW-1:0] r_addr,
  input logic          l_irq_n,
  input logic          r_irq_n
);
  localparam logic [AW-1:0] TOPW  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXTW = TOPW - 1'b1;

  logic l_post, r_post, l_take, r_take;
  assign l_post = l_sel && l_wr && !l_busy && (l_addr == TOPW);
  assign r_post = r_sel && r_wr && !r_busy && (r_addr == NEXTW);
  assign l_take = l_sel && !l_wr && l_oe && !l_busy && (l_addr == NEXTW);
  assign r_take = r_sel && !r_wr && r_oe && !r_busy && (r_addr == TOPW);

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (l_irq_n && r_irq_n);
    end
  end

  a_r2_left_post_raises: assert property (@(posedge clk) disable iff (!rst_n)
    l_post |=> !r_irq_n);
  a_r3_right_post_raises: assert property (@(posedge clk) disable iff (!rst_n)
    r_post |=> !l_irq_n);
  a_r4_left_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (l_take && !r_post) |=> l_irq_n);
  a_r5_right_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (r_take && !l_post) |=> r_irq_n);
  a_r7_r_fall_needs_post: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_irq_n) |-> $past(l_post));
  a_r7_l_fall_needs_post: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_irq_n) |-> $past(r_post));
  a_r8_l_rise_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l_irq_n) |-> $past(l_take));
  a_r8_r_rise_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_irq_n) |-> $past(r_take));
endmodule

bind mbx_irq_top mbx_irq_chk #(.AW(AW)) u_chk (.*);

// File: tb/mbx_irq_top_tb.sv
module mbx_irq_top_tb_top;
  localparam int AW = 4;
  localparam int TOPA = 15;
  localparam int NEXTA = 14;

  typedef struct {
    logic  l_n;
    logic  r_n;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_wr = 0, l_oe = 0, l_busy = 0;
  logic r_sel = 0, r_wr = 0, r_oe = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;

  int vectors = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb[$];
  bit m_l = 0, m_r = 0; // model: flag raised

  always #2 clk = ~clk;

  mbx_irq_top #(.AW(AW)) dut_i (.*);

  task automatic check(input logic al, input logic ar, input logic el,
                       input logic er, input string req);
    vectors++;
    if (al !== el || ar !== er) begin
      errors++;
      $display("FAIL %s: irq_n l/r actual %b%b expected %b%b", req, al, ar, el, er);
    end
  endtask

  task automatic step(input bit ls, input bit lw, input bit lo, input bit lb, input int la,
                      input bit rs, input bit rw, input bit ro, input bit rb, input int ra,
                      input string req);
    bit lp, rp, lt, rt;
    exp_t e;
    @(negedge clk);
    l_sel = ls; l_wr = lw; l_oe = lo; l_busy = lb; l_addr = AW'(la);
    r_sel = rs; r_wr = rw; r_oe = ro; r_busy = rb; r_addr = AW'(ra);
    lp = ls && lw && !lb && la == TOPA;
    rp = rs && rw && !rb && ra == NEXTA;
    lt = ls && !lw && lo && !lb && la == NEXTA;
    rt = rs && !rw && ro && !rb && ra == TOPA;
    m_l = rp ? 1'b1 : (lt ? 1'b0 : m_l);
    m_r = lp ? 1'b1 : (rt ? 1'b0 : m_r);
    e.l_n = !m_l; e.r_n = !m_r; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input string req);
    step(0,0,0,0,0, 0,0,0,0,0, req);
  endtask

  // Monitor: one result per applied vector, sampled after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(l_irq_n, r_irq_n, e.l_n, e.r_n, e.req);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 check(l_irq_n, r_irq_n, 1'b1, 1'b1, "R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    idle("R1 after reset");
    step(1,1,0,0,TOPA,  0,0,0,0,0,     "R2 left posts");
    idle("R11 hold");
    step(1,0,1,0,TOPA,  0,0,0,0,0,     "R6 left reads peer box");
    step(0,0,0,0,0,     1,0,0,0,TOPA,  "R5 read without oe");
    step(0,0,0,0,0,     1,0,1,1,TOPA,  "R8 right busy read");
    step(0,0,0,0,0,     1,0,1,0,TOPA,  "R5 right takes");
    step(0,0,0,0,0,     1,1,0,1,NEXTA, "R7 right busy post");
    step(0,0,0,0,0,     1,1,0,0,NEXTA, "R3 right posts");
    step(0,0,0,0,0,     1,0,1,0,NEXTA, "R6 right reads peer box");
    step(1,1,0,0,NEXTA, 0,0,0,0,0,     "R10 left writes own box");
    step(1,0,1,1,NEXTA, 0,0,0,0,0,     "R8 left busy read");
    step(1,0,1,0,NEXTA, 0,0,0,0,0,     "R4 left takes");
    step(0,1,0,0,TOPA,  0,1,0,0,NEXTA, "R10 select low");
    step(1,1,0,0,3,     1,1,0,0,3,     "R10 other address");
    step(0,0,0,0,0,     1,1,0,0,TOPA,  "R10 right writes own box");
    step(1,1,0,1,TOPA,  0,0,0,0,0,     "R7 left busy post");
    step(1,0,1,0,NEXTA, 1,1,0,0,NEXTA, "R9 left set wins");
    step(1,1,0,0,TOPA,  1,0,1,0,TOPA,  "R9 right set wins");
    idle("R11 hold both");
    step(1,0,1,0,NEXTA, 1,0,1,0,TOPA,  "R4 R5 both take");
    step(1,1,0,0,TOPA,  1,1,0,0,NEXTA, "R2 R3 both post");
    idle("R11 hold after post");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule